// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block sits between a register write port and an external sample converter. It holds an 8-bit command word made of a differential flag, a conversion mode and a start source. From these it decides when to send a one-cycle conversion request to the converter. A request can be started in three ways: immediately, by a write to the input-select register, or by an external event pulse. It then collects the converter's done/data answers and turns them into a result, either one sample or a sum of samples.

In single mode every conversion produces its own result. In series mode the block needs one trigger per conversion and adds the samples until the sample count is reached. In burst mode a single trigger runs the whole counted sequence back to back. Samples are zero-extended when the differential flag is clear and sign-extended when it is set. At most one request is outstanding at any time. Writing the stop code cancels whatever is in flight.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset the command word reads 0x00, and `conv_req` and `res_valid` are low.
- R2: A command write stores bit 7 as the differential flag, bits 6:4 as the mode (0 none, 1 single, 2 series, 3 burst, 7 accumulator test, others reserved) and bits 2:0 as the start field. Bit 3 always reads back 0.
- R3: Writing start code 1 (immediate) while `enable` is 0 stores start code 0 (stop) and issues no request.
- R4: Start code 1 issues a request while the block is idle. Start code 2 issues one on a write with `wr_sel`=1. Start code 4 issues one on `evt_pulse` only when `evt_en` is 1, and the event is ignored otherwise.
- R5: Modes 0, 4, 5, 6 and 7, and start codes 3, 5, 6 and 7, never produce a request.
- R6: In single mode each conversion gives a one-cycle `res_valid` in the cycle after `conv_done`, carrying the extended sample.
- R7: In series mode each trigger issues exactly one request. After `samp_cnt`+1 conversions, the result is their sum. No result appears earlier.
- R8: In burst mode one trigger issues `samp_cnt`+1 requests. Each follow-on request comes in the cycle after the previous `conv_done`. One result carries the sum.
- R9: With the differential flag at 1 samples are sign-extended; with it at 0 they are zero-extended. The sum restarts from zero at the first sample of each sequence.
- R10: When a result is produced with start code 1, the start field returns to 0 unless `free_run` is 1. With `free_run` at 1, conversions keep repeating.
- R11: A command write that stores start code 0 aborts the sequence in progress. No result follows, a late `conv_done` is ignored, and the next sequence starts from a cleared sum.
- R12: While a request awaits `conv_done`, further triggers are dropped.
- R13: With `enable` at 0 no trigger starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the command word, 1 the input-select register |
| wr_data | input | 8 | Write data (command word layout for wr_sel=0) |
| enable | input | 1 | Block enable |
| free_run | input | 1 | Keep repeating immediate-started conversions |
| evt_en | input | 1 | Allow event-started conversions |
| samp_cnt | input | CNT_W | Samples per series/burst sequence, minus one |
| evt_pulse | input | 1 | External start event |
| conv_done | input | 1 | Converter finished, data valid |
| conv_data | input | DW | Converter sample |
| conv_req | output | 1 | One-cycle conversion request |
| cmd_word | output | 8 | Current command word |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DW+CNT_W | Extended sample or accumulated sum |

## Verification
The bench builds the block with DW=4 and CNT_W=2. With these values every sample code, both extension modes and every sequence length from one to four can be swept completely. The expected sums come from plain integer arithmetic on a known sample pattern. The narrow sum width (6 bits) also means negative sums wrap into the field and are checked modulo its size.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam logic [2:0] MODE_NONE   = 3'd0;
  localparam logic [2:0] MODE_SINGLE = 3'd1;
  localparam logic [2:0] MODE_SERIES = 3'd2;
  localparam logic [2:0] MODE_BURST  = 3'd3;
  localparam logic [2:0] MODE_ACCTST = 3'd7;

  localparam logic [2:0] START_STOP  = 3'd0;
  localparam logic [2:0] START_IMM   = 3'd1;
  localparam logic [2:0] START_INSEL = 3'd2;
  localparam logic [2:0] START_EVT   = 3'd4;

  typedef struct packed {
    logic       diff;
    logic [2:0] mode;
    logic       rsvd;
    logic [2:0] start;
  } cmd_t;
endpackage

// File: rtl/adc_cmd_reg.sv
module adc_cmd_reg
  import adc_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_cmd,
  input  logic [7:0] wdata,
  input  logic       enable,
  input  logic       free_run,
  input  logic       seq_fin,
  output cmd_t       cmd_q,
  output logic       abort
);
  logic [2:0] start_new;

  always_comb begin
    start_new = wdata[2:0];
    if (start_new == START_IMM && !enable) start_new = START_STOP;
  end

  assign abort = wr_cmd && (start_new == START_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (wr_cmd) begin
      cmd_q.diff  <= wdata[7];
      cmd_q.mode  <= wdata[6:4];
      cmd_q.rsvd  <= wdata[3] & 1'b0;  // no storage behind bit 3
      cmd_q.start <= start_new;
    end else if (seq_fin && cmd_q.start == START_IMM && !free_run) begin
      cmd_q.start <= START_STOP;
    end
  end

  AST_IMM_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    wr_cmd && wdata[2:0] == START_IMM && !enable |=> cmd_q.start == START_STOP); // R3
  AST_FREE_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    seq_fin && !wr_cmd && free_run |=> $stable(cmd_q.start)); // R10
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_trig_pkg::*;
(
  input  logic       enable,
  input  logic       evt_en,
  input  logic [2:0] start,
  input  logic [2:0] mode,
  input  logic       insel_wr,
  input  logic       evt,
  output logic       mode_ok,
  output logic       trig
);
  logic src_hit;

  always_comb begin
    mode_ok = (mode == MODE_SINGLE) || (mode == MODE_SERIES) || (mode == MODE_BURST);
    case (start)
      START_IMM:   src_hit = 1'b1;
      START_INSEL: src_hit = insel_wr;
      START_EVT:   src_hit = evt && evt_en;
      default:     src_hit = 1'b0;
    endcase
    trig = enable && mode_ok && src_hit;
  end
endmodule

// File: rtl/adc_accum.sv
module adc_accum #(
  parameter int DW    = 12,
  parameter int CNT_W = 4,
  localparam int AW   = DW + CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          first,
  input  logic          diff,
  input  logic [DW-1:0] sample,
  output logic [AW-1:0] sum
);
  logic [AW-1:0] acc_q;
  logic [AW-1:0] ext;

  always_comb begin
    ext = diff ? {{(AW-DW){sample[DW-1]}}, sample} : {{(AW-DW){1'b0}}, sample};
    sum = (first ? '0 : acc_q) + ext;
  end

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (load) acc_q <= sum;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_trig_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CNT_W = 4,
  localparam int AW   = DW + CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic             abort,
  input  logic             mode_ok,
  input  logic [2:0]       mode,
  input  logic [CNT_W-1:0] samp_cnt,
  input  logic             conv_done,
  input  logic [AW-1:0]    sum,
  output logic             acc_load,
  output logic             acc_first,
  output logic             seq_fin,
  output logic             conv_req,
  output logic             res_valid,
  output logic [AW-1:0]    res_data
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accum_mode;
  logic             last;

  always_comb begin
    accum_mode = (mode == MODE_SERIES) || (mode == MODE_BURST);
    last       = !accum_mode || (cnt_q == samp_cnt);
    acc_load   = busy_q && conv_done && !abort;
    acc_first  = (cnt_q == '0);
    seq_fin    = acc_load && last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      conv_req  <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      conv_req  <= 1'b0;
      res_valid <= 1'b0;
      if (abort) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (!busy_q) begin
        if (trig) begin
          busy_q   <= 1'b1;
          conv_req <= 1'b1;
        end
      end else if (conv_done) begin
        if (last) begin
          res_valid <= 1'b1;
          res_data  <= sum;
          cnt_q     <= '0;
          busy_q    <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (mode == MODE_BURST) conv_req <= 1'b1;
          else                    busy_q   <= 1'b0;
        end
      end
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    conv_req && !conv_done |=> !conv_req); // R12
  AST_RESERVED_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> $past(mode_ok)); // R5
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R6
  AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (rst)
    abort |=> !conv_req && !res_valid); // R11
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_trig_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CNT_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [7:0]          wr_data,
  input  logic                enable,
  input  logic                free_run,
  input  logic                evt_en,
  input  logic [CNT_W-1:0]    samp_cnt,
  input  logic                evt_pulse,
  input  logic                conv_done,
  input  logic [DW-1:0]       conv_data,
  output logic                conv_req,
  output logic [7:0]          cmd_word,
  output logic                res_valid,
  output logic [DW+CNT_W-1:0] res_data
);
  localparam int AW = DW + CNT_W;

  cmd_t          cmd_q;
  logic          abort, seq_fin, mode_ok, trig;
  logic          acc_load, acc_first;
  logic [AW-1:0] sum;
  logic          wr_cmd, wr_insel;

  assign wr_cmd   = wr_en && !wr_sel;
  assign wr_insel = wr_en && wr_sel;
  assign cmd_word = cmd_q;

  adc_cmd_reg u_cmd (
    .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .wdata(wr_data), .enable(enable),
    .free_run(free_run), .seq_fin(seq_fin), .cmd_q(cmd_q), .abort(abort)
  );

  adc_trig_sel u_sel (
    .enable(enable), .evt_en(evt_en), .start(cmd_q.start), .mode(cmd_q.mode),
    .insel_wr(wr_insel), .evt(evt_pulse), .mode_ok(mode_ok), .trig(trig)
  );

  adc_accum #(.DW(DW), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .load(acc_load), .first(acc_first),
    .diff(cmd_q.diff), .sample(conv_data), .sum(sum)
  );

  adc_seq_ctrl #(.DW(DW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .trig(trig), .abort(abort), .mode_ok(mode_ok),
    .mode(cmd_q.mode), .samp_cnt(samp_cnt), .conv_done(conv_done), .sum(sum),
    .acc_load(acc_load), .acc_first(acc_first), .seq_fin(seq_fin),
    .conv_req(conv_req), .res_valid(res_valid), .res_data(res_data)
  );

  AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable && !conv_req && $stable(cmd_q) && cmd_q.mode != MODE_BURST |=> !conv_req); // R13
endmodule

// File: tb/adc_trig_seq_test.sv
module adc_trig_seq_test;
  localparam int DW = 4, CNT_W = 2, AW = DW + CNT_W;

  logic clk = 0, rst = 1;
  logic wr_en = 0, wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic enable = 0, free_run = 0, evt_en = 0, evt_pulse = 0;
  logic [CNT_W-1:0] samp_cnt = 0;
  logic conv_done = 0;
  logic [DW-1:0] conv_data = 0;
  logic conv_req, res_valid;
  logic [7:0] cmd_word;
  logic [AW-1:0] res_data;

  int n_chk = 0, n_bad = 0;
  int req_cnt = 0, res_cnt = 0, res_last = 0, resp_idx = 0;

  always #5 clk = ~clk;

  adc_trig_seq #(.DW(DW), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .enable(enable), .free_run(free_run), .evt_en(evt_en), .samp_cnt(samp_cnt),
    .evt_pulse(evt_pulse), .conv_done(conv_done), .conv_data(conv_data),
    .conv_req(conv_req), .cmd_word(cmd_word), .res_valid(res_valid), .res_data(res_data)
  );

  function automatic int samp(int i);
    return (i * 7 + 3) & 15;
  endfunction
  function automatic int ext(int v, int d);
    return (d != 0 && v >= 8) ? v - 16 : v;
  endfunction
  function automatic int seq_sum(int base, int n, int d);
    int s = 0;
    for (int i = 0; i < n; i++) s += ext(samp(base + i), d);
    return s & ((1 << AW) - 1);
  endfunction

  task automatic check(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask
  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0; wr_sel = 0;
  endtask
  task automatic pulse_evt();
    @(negedge clk); evt_pulse = 1;
    @(negedge clk); evt_pulse = 0;
  endtask

  // converter model: answers each request two cycles later
  initial forever begin
    @(negedge clk);
    conv_done = 0;
    if (conv_req) begin
      repeat (2) @(negedge clk);
      conv_data = DW'(samp(resp_idx));
      resp_idx++;
      conv_done = 1;
    end
  end

  // output monitor
  initial forever begin
    @(negedge clk);
    if (conv_req) req_cnt++;
    if (res_valid) begin res_cnt++; res_last = int'(res_data); end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int r0, q0, base, n;
    idle(3); rst = 0; idle(1);
    check("R1 cmd", int'(cmd_word), 0);
    check("R1 req", int'(conv_req), 0);
    check("R1 valid", int'(res_valid), 0);
    enable = 1;

    // R2 field layout, bit 3 reads zero
    wr(0, 8'h2E); check("R2 word", int'(cmd_word), 8'h26);
    r0 = req_cnt; wr(0, 8'hF3); check("R2 word", int'(cmd_word), 8'hF3);
    wr(1, 8'h00); idle(6); check("R5 mode7 start3", req_cnt - r0, 0);

    // R3 immediate while disabled
    enable = 0; r0 = req_cnt;
    wr(0, 8'h11); idle(6);
    check("R3 stored stop", int'(cmd_word), 8'h10);
    check("R3 no req", req_cnt - r0, 0);
    // R13 disabled ignores input-select trigger
    wr(0, 8'h12); wr(1, 8'h00); idle(6);
    check("R13 no req", req_cnt - r0, 0);
    enable = 1;

    // R5 reserved/none modes
    for (int m = 0; m < 8; m++) begin
      if (m >= 1 && m <= 3) continue;
      r0 = req_cnt;
      wr(0, {1'b0, 3'(m), 4'b0010}); wr(1, 8'h00); idle(6);
      check("R5 mode", req_cnt - r0, 0);
    end
    // R5 reserved start codes
    evt_en = 1;
    for (int s = 3; s < 8; s++) begin
      if (s == 4) continue;
      r0 = req_cnt;
      wr(0, {4'b0001, 1'b0, 3'(s)}); wr(1, 8'h00); pulse_evt(); idle(6);
      check("R5 start", req_cnt - r0, 0);
    end

    // R6/R9/R10 single, immediate, every sample code, both extensions
    for (int d = 0; d < 2; d++) begin
      for (int k = 0; k < 16; k++) begin
        r0 = req_cnt; q0 = res_cnt; base = resp_idx;
        wr(0, {1'(d), 3'd1, 4'b0001}); idle(8);
        check("R6 one req", req_cnt - r0, 1);
        check("R6 one result", res_cnt - q0, 1);
        check("R9 extended sample", res_last, ext(samp(base), d) & ((1 << AW) - 1));
        check("R10 start cleared", int'(cmd_word[2:0]), 0);
      end
    end

    // R4/R7 series via input-select writes
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 4; c++) begin
        samp_cnt = CNT_W'(c); n = c + 1;
        wr(0, {1'(d), 3'd2, 4'b0010});
        r0 = req_cnt; q0 = res_cnt; base = resp_idx;
        for (int j = 0; j < n; j++) begin
          wr(1, 8'h5A); idle(6);
          if (j < n - 1) check("R7 no early result", res_cnt - q0, 0);
        end
        check("R4 R7 one req per trigger", req_cnt - r0, n);
        check("R7 one result", res_cnt - q0, 1);
        check("R7 R9 sum", res_last, seq_sum(base, n, d));
      end
    end

    // R4/R8 burst via event
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 4; c++) begin
        samp_cnt = CNT_W'(c); n = c + 1;
        wr(0, {1'(d), 3'd3, 4'b0100});
        r0 = req_cnt; q0 = res_cnt; base = resp_idx;
        pulse_evt(); idle(4 * n + 8);
        check("R8 reqs", req_cnt - r0, n);
        check("R8 one result", res_cnt - q0, 1);
        check("R8 R9 sum", res_last, seq_sum(base, n, d));
      end
    end

    // R4 event ignored without event enable
    evt_en = 0; r0 = req_cnt;
    pulse_evt(); idle(6);
    check("R4 event ignored", req_cnt - r0, 0);
    evt_en = 1;

    // R12 trigger while waiting is dropped
    samp_cnt = 2'd1;
    wr(0, 8'h22);
    r0 = req_cnt; q0 = res_cnt; base = resp_idx;
    @(negedge clk); wr_en = 1; wr_sel = 1;
    @(negedge clk);
    @(negedge clk); wr_en = 0; wr_sel = 0;
    idle(6);
    check("R12 dropped trigger", req_cnt - r0, 1);
    check("R12 no result yet", res_cnt - q0, 0);
    wr(1, 8'h00); idle(6);
    check("R12 sum", res_last, seq_sum(base, 2, 0));

    // R11 abort a burst, late done ignored, next sum fresh
    samp_cnt = 2'd3;
    wr(0, 8'h34); q0 = res_cnt;
    pulse_evt(); idle(2);
    wr(0, 8'h30); idle(8);
    r0 = req_cnt; idle(10);
    check("R11 no more reqs", req_cnt - r0, 0);
    check("R11 no result", res_cnt - q0, 0);
    wr(0, 8'h34); base = resp_idx; q0 = res_cnt;
    pulse_evt(); idle(24);
    check("R11 fresh result", res_cnt - q0, 1);
    check("R11 fresh sum", res_last, seq_sum(base, 4, 0));

    // R10 free-running immediate keeps going
    free_run = 1; r0 = req_cnt;
    wr(0, 8'h11); idle(30);
    check("R10 start held", int'(cmd_word[2:0]), 1);
    check("R10 repeated reqs", int'((req_cnt - r0) >= 3), 1);
    wr(0, 8'h10); idle(6);
    r0 = req_cnt; idle(10);
    check("R11 stop ends free run", req_cnt - r0, 0);
    free_run = 0;

    finish_run();
  end
endmodule